// File: doc/BRIEF.md
# STM-1 Frame Alignment Detector

This block watches a byte-aligned STM-1 line stream, one byte per byte-clock cycle, and locks a byte position counter to the frame. While hunting it looks at every byte position for the six-byte alignment word. That word is three 0xF6 bytes followed by three 0x28 bytes. When the word is found, the counter is set so that the byte after the word carries index 6.

After this first find, the counter free-runs through the 2430-byte frame. The frame is 9 rows of 270 bytes, so row r, column c sits at index 270·r + c. The alignment word is checked only once per frame, in its expected slot at indices 0 to 5. Two frames in a row with the word in place raise the in-frame flag. Four frames in a row without it drop the flag and restart the hunt.

Downstream logic uses `byte_idx` to pick overhead and payload bytes out of the stream. It uses `frame_start` as a one-cycle marker at index 0 of each locked frame.

Top module: `stm_frame_align`

## Requirements
- R1: A synchronous active-high reset sets `byte_idx` to 0 and `in_frame` to 0, with `frame_start` low, and puts the block in the hunt state.
- R2: When not reloaded, `byte_idx` advances by one on every clock and wraps from 2429 to 0.
- R3: The alignment word is exactly 0xF6, 0xF6, 0xF6, 0x28, 0x28, 0x28 on consecutive clocks. Shorter or reordered runs do not reload the counter.
- R4: In the hunt state, when the last byte of the word is on `din`, `byte_idx` is 6 in the next cycle. The block then waits for confirmation with `in_frame` still 0.
- R5: While confirming, a word that ends at index 5 of the next frame raises `in_frame` in the cycle where `byte_idx` becomes 6.
- R6: While confirming, a missing word at indices 0 to 5 returns the block to the hunt state with `in_frame` still 0, so a word at any later position is acquired again.
- R7: While confirming or in frame, an alignment word at any position other than 0 to 5 leaves `byte_idx` undisturbed.
- R8: In frame, `in_frame` falls in the cycle where `byte_idx` becomes 6 of the fourth frame in a row without the word. A correct frame resets this count.
- R9: `frame_start` is high exactly when `in_frame` is 1 and `byte_idx` is 0, which is one cycle per frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 8 | Byte-aligned line data |
| byte_idx | output | 12 | Index, within the frame, of the byte now on `din` |
| in_frame | output | 1 | High while alignment is confirmed |
| frame_start | output | 1 | One-cycle marker at index 0 of a locked frame |

## Verification
The assertions take for granted that `din` is byte-aligned, with one new byte every clock and no idle cycles, so that the fixed spacing of 2430 between words holds. They also rely on the two word bytes being different values, which is why a hit can never follow a hit on the next clock.

The stimulus always drives a byte on every cycle. Random payload is drawn with 0xF6 and 0x28 excluded, so the only words on the line are the ones the bench places on purpose. Misplaced words, bad frames and frame slips are placed deliberately, by directed sequences and by a seeded random frame mix.

// File: rtl/sfa_pkg.sv
`timescale 1ns/1ps
package sfa_pkg;
   typedef enum logic [1:0] {
      ST_HUNT    = 2'd0,
      ST_PRESYNC = 2'd1,
      ST_SYNC    = 2'd2
   } sfa_state_e;
endpackage

// File: rtl/sfa_pattern_det.sv
`timescale 1ns/1ps
module sfa_pattern_det #(
   parameter int                DATA_W  = 8,
   parameter logic [DATA_W-1:0] A1_BYTE = 8'hF6,
   parameter logic [DATA_W-1:0] A2_BYTE = 8'h28,
   parameter int                A1_CNT  = 3,
   parameter int                A2_CNT  = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] din,
   output logic              hit
);
   localparam int PAT_LEN = A1_CNT + A2_CNT;

   // hist[0] is the previous byte, hist[PAT_LEN-2] the oldest kept
   logic [PAT_LEN-2:0][DATA_W-1:0] hist;
   logic [PAT_LEN-1:0]             eq;

   initial begin
      assert (PAT_LEN >= 3) else $fatal(1, "pattern must be at least 3 bytes");
      assert (A1_BYTE != A2_BYTE) else $fatal(1, "word bytes must differ");
   end

   always_ff @(posedge clk) begin
      if (rst) hist <= '0;
      else     hist <= {hist[PAT_LEN-3:0], din};
   end

   assign eq[PAT_LEN-1] = (din == A2_BYTE);

   for (genvar k = 0; k < PAT_LEN - 1; k++) begin : g_tap
      localparam int POS = PAT_LEN - 2 - k;
      localparam logic [DATA_W-1:0] EXP = (POS < A1_CNT) ? A1_BYTE : A2_BYTE;
      assign eq[POS] = (hist[k] == EXP);
   end

   assign hit = &eq;

   AST_HIT_SPACED: assert property (@(posedge clk) disable iff (rst)
      hit |=> !hit); // R3
endmodule

// File: rtl/sfa_pos_counter.sv
`timescale 1ns/1ps
module sfa_pos_counter #(
   parameter int FRAME_LEN = 2430,
   parameter int LOAD_VAL  = 6,
   parameter int CHECK_IDX = 5,
   parameter int IDX_W     = $clog2(FRAME_LEN)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   output logic [IDX_W-1:0] idx,
   output logic             at_check
);
   localparam logic [IDX_W-1:0] LAST_I  = IDX_W'(FRAME_LEN - 1);
   localparam logic [IDX_W-1:0] LOAD_I  = IDX_W'(LOAD_VAL);
   localparam logic [IDX_W-1:0] CHECK_I = IDX_W'(CHECK_IDX);

   initial begin
      assert (FRAME_LEN > LOAD_VAL) else $fatal(1, "frame shorter than word");
      assert ((1 << IDX_W) >= FRAME_LEN) else $fatal(1, "IDX_W too small");
   end

   always_ff @(posedge clk) begin
      if (rst)                 idx <= '0;
      else if (load)           idx <= LOAD_I;
      else if (idx == LAST_I)  idx <= '0;
      else                     idx <= idx + 1'b1;
   end

   assign at_check = (idx == CHECK_I);

   AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
      idx <= LAST_I); // R2
   AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
      !load |=> ((idx == '0) ? ($past(idx) == LAST_I) : (idx == $past(idx) + 1'b1))); // R2
   AST_LOAD_SIX: assert property (@(posedge clk) disable iff (rst)
      load |=> (idx == LOAD_I)); // R4
endmodule

// File: rtl/sfa_frame_fsm.sv
`timescale 1ns/1ps
module sfa_frame_fsm
   import sfa_pkg::*;
#(
   parameter int GOOD_FRAMES = 2,
   parameter int BAD_FRAMES  = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic hit,
   input  logic at_check,
   output logic load,
   output logic in_frame
);
   localparam int GW = $clog2(GOOD_FRAMES + 1);
   localparam int BW = $clog2(BAD_FRAMES + 1);
   localparam logic [GW-1:0] GOOD_LAST = GW'(GOOD_FRAMES - 1);
   localparam logic [BW-1:0] BAD_LAST  = BW'(BAD_FRAMES - 1);

   sfa_state_e    state;
   logic [GW-1:0] good_cnt;
   logic [BW-1:0] bad_cnt;

   initial begin
      assert (GOOD_FRAMES >= 1) else $fatal(1, "GOOD_FRAMES must be >= 1");
      assert (BAD_FRAMES >= 1) else $fatal(1, "BAD_FRAMES must be >= 1");
   end

   assign load     = (state == ST_HUNT) && hit;
   assign in_frame = (state == ST_SYNC);

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= ST_HUNT;
         good_cnt <= '0;
         bad_cnt  <= '0;
      end else begin
         case (state)
            ST_HUNT: begin
               if (hit) begin
                  if (GOOD_FRAMES <= 1) begin
                     state   <= ST_SYNC;
                     bad_cnt <= '0;
                  end else begin
                     state    <= ST_PRESYNC;
                     good_cnt <= GW'(1);
                  end
               end
            end
            ST_PRESYNC: begin
               if (at_check) begin
                  if (!hit) begin
                     state <= ST_HUNT;
                  end else if (good_cnt == GOOD_LAST) begin
                     state   <= ST_SYNC;
                     bad_cnt <= '0;
                  end else begin
                     good_cnt <= good_cnt + 1'b1;
                  end
               end
            end
            ST_SYNC: begin
               if (at_check) begin
                  if (hit)                     bad_cnt <= '0;
                  else if (bad_cnt == BAD_LAST) state  <= ST_HUNT;
                  else                         bad_cnt <= bad_cnt + 1'b1;
               end
            end
            default: state <= ST_HUNT;
         endcase
      end
   end

   AST_LOCK_ON_HIT: assert property (@(posedge clk) disable iff (rst)
      $rose(in_frame) |-> $past(hit)); // R5
   AST_LOSS_ON_MISS: assert property (@(posedge clk) disable iff (rst)
      ($fell(in_frame) && !$past(rst)) |-> $past(at_check && !hit)); // R8
endmodule

// File: rtl/stm_frame_align.sv
`timescale 1ns/1ps
module stm_frame_align #(
   parameter int                DATA_W      = 8,
   parameter logic [DATA_W-1:0] A1_BYTE     = 8'hF6,
   parameter logic [DATA_W-1:0] A2_BYTE     = 8'h28,
   parameter int                A1_CNT      = 3,
   parameter int                A2_CNT      = 3,
   parameter int                FRAME_LEN   = 2430,
   parameter int                GOOD_FRAMES = 2,
   parameter int                BAD_FRAMES  = 4,
   parameter int                IDX_W       = $clog2(FRAME_LEN)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] din,
   output logic [IDX_W-1:0]  byte_idx,
   output logic              in_frame,
   output logic              frame_start
);
   localparam int PAT_LEN = A1_CNT + A2_CNT;

   logic hit;
   logic load;
   logic at_check;

   sfa_pattern_det #(
      .DATA_W (DATA_W), .A1_BYTE(A1_BYTE), .A2_BYTE(A2_BYTE),
      .A1_CNT (A1_CNT), .A2_CNT (A2_CNT)
   ) u_det (
      .clk(clk), .rst(rst), .din(din), .hit(hit)
   );

   sfa_pos_counter #(
      .FRAME_LEN(FRAME_LEN), .LOAD_VAL(PAT_LEN),
      .CHECK_IDX(PAT_LEN - 1), .IDX_W(IDX_W)
   ) u_cnt (
      .clk(clk), .rst(rst), .load(load), .idx(byte_idx), .at_check(at_check)
   );

   sfa_frame_fsm #(
      .GOOD_FRAMES(GOOD_FRAMES), .BAD_FRAMES(BAD_FRAMES)
   ) u_fsm (
      .clk(clk), .rst(rst), .hit(hit), .at_check(at_check),
      .load(load), .in_frame(in_frame)
   );

   assign frame_start = in_frame && (byte_idx == '0);

   AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
      frame_start |=> !frame_start); // R9
   AST_NO_RELOAD_LOCKED: assert property (@(posedge clk) disable iff (rst)
      (in_frame && !at_check) |=> (byte_idx != '0 || $past(byte_idx) == IDX_W'(FRAME_LEN - 1))); // R7
endmodule

// File: tb/stm_frame_align_tb.sv
`timescale 1ns/1ps
module stm_frame_align_tb_top;
   localparam logic [7:0] A1 = 8'hF6;
   localparam logic [7:0] A2 = 8'h28;
   localparam int FLEN = 2430;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  din = 8'h00;
   logic [11:0] byte_idx;
   logic        in_frame;
   logic        frame_start;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // reference model state
   int         m_idx, m_st, m_good, m_bad;
   logic [7:0] mh [5];

   always #4 clk = ~clk;

   stm_frame_align dut_i (
      .clk(clk), .rst(rst), .din(din),
      .byte_idx(byte_idx), .in_frame(in_frame), .frame_start(frame_start)
   );

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d idx=%0d", tag, act, exp, byte_idx);
      end
   endtask

   function automatic bit model_hit(logic [7:0] b);
      return mh[4] == A1 && mh[3] == A1 && mh[2] == A1 &&
             mh[1] == A2 && mh[0] == A2 && b == A2;
   endfunction

   task automatic model_step(logic [7:0] b);
      bit h;
      int nidx;
      h = model_hit(b);
      if (rst) begin
         m_idx = 0; m_st = 0; m_good = 0; m_bad = 0;
         for (int i = 0; i < 5; i++) mh[i] = 8'h00;
         return;
      end
      nidx = (m_idx == FLEN - 1) ? 0 : m_idx + 1;
      case (m_st)
         0: if (h) begin m_st = 1; m_good = 1; nidx = 6; end
         1: if (m_idx == 5) begin
               if (h) begin m_st = 2; m_bad = 0; end
               else m_st = 0;
            end
         default: if (m_idx == 5) begin
               if (h) m_bad = 0;
               else begin
                  m_bad++;
                  if (m_bad == 4) m_st = 0;
               end
            end
      endcase
      m_idx = nidx;
      for (int i = 4; i > 0; i--) mh[i] = mh[i-1];
      mh[0] = b;
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic step(logic [7:0] b);
      check("R2 idx", int'(byte_idx), m_idx);
      check("R5 in_frame", int'(in_frame), (m_st == 2) ? 1 : 0);
      check("R9 frame_start", int'(frame_start), (m_st == 2 && m_idx == 0) ? 1 : 0);
      din = b;
      model_step(b);
      @(negedge clk);
   endtask

   function automatic logic [7:0] pay();
      logic [7:0] v;
      v = 8'($urandom_range(0, 255));
      if (v == A1 || v == A2) v = 8'h55;
      return v;
   endfunction

   function automatic logic [7:0] word_byte(int p);
      return (p < 3) ? A1 : A2;
   endfunction

   task automatic send_range(bit good, int inj, int from, int upto);
      for (int p = from; p < upto; p++) begin
         if (good && p < 6)                          step(word_byte(p));
         else if (inj >= 6 && p >= inj && p < inj + 6) step(word_byte(p - inj));
         else                                        step(pay());
      end
   endtask

   task automatic send_frame(bit good, int inj);
      send_range(good, inj, 0, FLEN);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         fails++;
         $display("FAIL R2 watchdog actual=hung expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20061125));
      @(negedge clk);
      rst = 1'b1;
      step(8'h00);
      step(8'h00);
      rst = 1'b0;
      // R1 reset state
      check("R1 idx", int'(byte_idx), 0);
      check("R1 in_frame", int'(in_frame), 0);
      check("R1 frame_start", int'(frame_start), 0);

      // R2 counting and wrap while hunting
      for (int i = 0; i < 777; i++) step(pay());
      check("R2 count", int'(byte_idx), 777);
      for (int i = 777; i < FLEN; i++) step(pay());
      check("R2 wrap", int'(byte_idx), 0);
      check("R9 no start out of frame", int'(frame_start), 0);

      // R3 partial and reordered words are not taken
      step(A1); step(A1); step(A2); step(A2); step(A2);
      step(A1); step(A1); step(A1); step(A2); step(A2); step(A1);
      check("R3 no reload", int'(byte_idx), 11);
      check("R3 in_frame", int'(in_frame), 0);

      // R4 first find
      send_range(1'b1, -1, 0, 6);
      check("R4 idx after find", int'(byte_idx), 6);
      check("R4 not yet in frame", int'(in_frame), 0);
      send_range(1'b0, -1, 6, FLEN);

      // R5 confirmation on the next frame
      send_range(1'b1, -1, 0, 6);
      check("R5 in_frame", int'(in_frame), 1);
      check("R5 idx", int'(byte_idx), 6);
      send_range(1'b0, -1, 6, FLEN);
      check("R9 start at idx0", int'(frame_start), 1);
      send_range(1'b1, -1, 0, 1);
      check("R9 start one cycle", int'(frame_start), 0);

      // R7 misplaced word ignored while in frame
      send_range(1'b1, 1000, 1, 1006);
      check("R7 idx undisturbed", int'(byte_idx), 1006);
      check("R7 in_frame", int'(in_frame), 1);
      send_range(1'b1, 1000, 1006, FLEN);

      // R8 three bad frames then a good one keeps lock
      for (int f = 0; f < 3; f++) send_frame(1'b0, -1);
      check("R8 after three bad", int'(in_frame), 1);
      send_range(1'b1, -1, 0, 6);
      check("R8 good resets count", int'(in_frame), 1);
      send_range(1'b1, -1, 6, FLEN);
      // four bad frames drop lock
      for (int f = 0; f < 3; f++) send_frame(1'b0, -1);
      send_range(1'b0, -1, 0, 6);
      check("R8 lost", int'(in_frame), 0);
      check("R8 idx", int'(byte_idx), 6);
      send_range(1'b0, -1, 6, FLEN);

      // R6 failed confirmation returns to hunting
      send_frame(1'b1, -1);
      send_range(1'b0, -1, 0, 6);
      check("R6 no lock", int'(in_frame), 0);
      send_range(1'b0, -1, 6, 100);
      send_range(1'b1, -1, 0, 6);
      check("R6 reacquired", int'(byte_idx), 6);
      send_range(1'b1, 500, 6, FLEN);
      // R7 misplaced word ignored while confirming: lock still comes at the find phase
      send_range(1'b1, -1, 0, 6);
      check("R7 confirm kept phase", int'(in_frame), 1);
      send_range(1'b1, -1, 6, FLEN);

      // random frame mix checked against the model
      for (int f = 0; f < 14; f++) begin
         int r;
         r = $urandom_range(0, 9);
         if (r < 7)       send_frame(1'b1, (r == 0) ? $urandom_range(10, 2000) : -1);
         else if (r < 9)  send_frame(1'b0, -1);
         else begin
            send_range(1'b0, -1, 0, $urandom_range(1, 50));
            send_frame(1'b1, -1);
         end
      end

      // R1 reset in the middle of the stream
      send_range(1'b1, -1, 0, 300);
      rst = 1'b1;
      step(pay());
      rst = 1'b0;
      check("R1 mid reset idx", int'(byte_idx), 0);
      check("R1 mid reset in_frame", int'(in_frame), 0);
      step(pay());

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule